// File: doc/BRIEF.md
# PLL-Branch Clock Divider Tree

This block turns one fast reference clock, which stands for a 96 MHz PLL output, into a set of clock-enable pulses at lower rates. Each output is high for one reference cycle per divided period. Logic that runs in the reference domain uses these pulses to advance at the lower rate. No output is a gated or generated clock.

There are five paths:
- An input prescaler, set by a 3-bit select, divides by 1, 2, 3, 4, 5, 6, 8 or 12. It gives the reference-rate enable.
- A full-rate enable and a half-rate enable serve downstream branches. A separate half-rate path serves the USB function.
- A system path applies a power-of-two postscaler and then a fixed divide-by-3. From a 96 MHz source this gives 32, 16, 8 or 4 MHz.
- An instruction-rate enable runs at half the system rate.

A change to a ratio select is picked up only when the current divided period ends. A period is therefore never cut short.

Top module: `pll_div_tree`

## Requirements
- R1: While `rst` is high at a clock edge, every enable output is low after that edge, and all counters return to zero. The select inputs present during reset give the first ratios.
- R2: `pre_sel` picks the prescaler ratio: 000→1, 001→2, 010→3, 011→4, 100→5, 101→6, 110→8, 111→12. `pre_en` pulses once every ratio cycles. The first pulse comes after the ratio-th edge following reset.
- R3: A new `pre_sel` value is sampled only at the edge that ends a prescaler period, and it sets the length of the next period.
- R4: `br96_en` is high in every cycle that follows an edge at which `rst` was low.
- R5: `br48_en` and `usb_en` each pulse on every second edge after reset, starting with the second edge. The two come from separate dividers and must stay equal.
- R6: `post_sel` picks the postscaler ratio: 00→1, 01→2, 10→4, 11→8. A fixed divide-by-3 follows it, so `sys_en` has a period of 3, 6, 12 or 24 cycles. The choice of `pre_sel` has no effect on `sys_en`.
- R7: A new `post_sel` value is sampled only at the edge that ends a postscaler period. That edge also produces the postscaler pulse, so no postscaler period is ever shortened.
- R8: `instr_en` pulses on every second `sys_en` pulse, starting with the second. It comes one cycle after that `sys_en` pulse.
- R9: Every divided enable whose active ratio is above 1 stays high for exactly one cycle at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock (represents 96 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| pre_sel | input | 3 | Prescaler ratio select |
| post_sel | input | 2 | System postscaler ratio select |
| br96_en | output | 1 | Full-rate branch enable |
| br48_en | output | 1 | Half-rate branch enable |
| usb_en | output | 1 | Half-rate USB enable |
| pre_en | output | 1 | Prescaled reference enable |
| sys_en | output | 1 | System clock enable |
| instr_en | output | 1 | Instruction-rate enable |

## Verification
Each output is registered, and its due cycle is counted in edges after reset is released:
- `br96_en` is due after edge 1.
- `br48_en` and `usb_en` are due after every even edge.
- `pre_en` is due after edge N·k, where N is the prescaler ratio.
- `sys_en` is due after edge 3P·k+1, where P is the postscaler ratio. The extra cycle is the register between the postscaler and the divide-by-3.
- `instr_en` is one further cycle after every second `sys_en` pulse.

The bench model holds countdowns that reload at the same period-ending edges. The select values it uses are the ones present at those edges. It compares every output on the falling edge after each rising edge, so the due cycle is checked exactly. Select changes are applied in the middle of periods, which exercises the boundary-only rule.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    localparam int PRE_SEL_W  = 3;
    localparam int POST_SEL_W = 2;
    localparam int DIV_W      = 4;   // holds the largest ratio (12)

    typedef logic [DIV_W-1:0] ratio_t;

    typedef struct packed {
        logic b96;
        logic b48;
        logic usb;
        logic pre;
        logic sys;
        logic instr;
    } en_bus_t;

    function automatic ratio_t pre_ratio(input logic [PRE_SEL_W-1:0] sel);
        case (sel)
            3'd0:    return ratio_t'(1);
            3'd1:    return ratio_t'(2);
            3'd2:    return ratio_t'(3);
            3'd3:    return ratio_t'(4);
            3'd4:    return ratio_t'(5);
            3'd5:    return ratio_t'(6);
            3'd6:    return ratio_t'(8);
            default: return ratio_t'(12);
        endcase
    endfunction

    function automatic ratio_t post_ratio(input logic [POST_SEL_W-1:0] sel);
        return ratio_t'(1) << sel;
    endfunction

endpackage

// File: rtl/pulse_div.sv
module pulse_div #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic [CW-1:0] ratio_in,
    output logic          pulse
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] ratio_q;
    logic          wrap;

    assign wrap = tick && (cnt == ratio_q - CW'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            ratio_q <= ratio_in;
            pulse   <= 1'b0;
        end else begin
            pulse <= wrap;
            if (tick) begin
                if (wrap) begin
                    cnt     <= '0;
                    ratio_q <= ratio_in;   // new ratio only at period end
                end else begin
                    cnt <= cnt + CW'(1);
                end
            end
        end
    end

    // R3 / R7: count never reaches the active ratio
    assert_cnt_range_R7: assert property (@(posedge clk) disable iff (rst)
        cnt < ratio_q);

    // R9: a pulse never repeats in the next cycle unless the ratio is 1
    assert_one_cycle_R9: assert property (@(posedge clk) disable iff (rst)
        (pulse && ratio_q != CW'(1)) |=> !pulse);

endmodule

// File: rtl/pll_div_tree.sv
module pll_div_tree
    import clkdiv_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic [PRE_SEL_W-1:0]  pre_sel,
    input  logic [POST_SEL_W-1:0] post_sel,
    output logic                  br96_en,
    output logic                  br48_en,
    output logic                  usb_en,
    output logic                  pre_en,
    output logic                  sys_en,
    output logic                  instr_en
);
    en_bus_t en;
    logic    post_pulse;
    logic    b96_q;

    always_ff @(posedge clk) begin
        b96_q <= !rst;
    end
    assign en.b96 = b96_q;

    pulse_div #(.CW(DIV_W)) u_pre (
        .clk(clk), .rst(rst), .tick(1'b1),
        .ratio_in(pre_ratio(pre_sel)), .pulse(en.pre));

    pulse_div #(.CW(DIV_W)) u_half (
        .clk(clk), .rst(rst), .tick(1'b1),
        .ratio_in(ratio_t'(2)), .pulse(en.b48));

    pulse_div #(.CW(DIV_W)) u_usb (
        .clk(clk), .rst(rst), .tick(1'b1),
        .ratio_in(ratio_t'(2)), .pulse(en.usb));

    pulse_div #(.CW(DIV_W)) u_post (
        .clk(clk), .rst(rst), .tick(1'b1),
        .ratio_in(post_ratio(post_sel)), .pulse(post_pulse));

    pulse_div #(.CW(DIV_W)) u_div3 (
        .clk(clk), .rst(rst), .tick(post_pulse),
        .ratio_in(ratio_t'(3)), .pulse(en.sys));

    pulse_div #(.CW(DIV_W)) u_instr (
        .clk(clk), .rst(rst), .tick(en.sys),
        .ratio_in(ratio_t'(2)), .pulse(en.instr));

    assign br96_en  = en.b96;
    assign br48_en  = en.b48;
    assign usb_en   = en.usb;
    assign pre_en   = en.pre;
    assign sys_en   = en.sys;
    assign instr_en = en.instr;

    // R4: full-rate enable follows a non-reset edge
    assert_full_rate_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!rst) |-> br96_en);

    // R5: the two half-rate dividers agree
    assert_usb_match_R5: assert property (@(posedge clk) disable iff (rst)
        usb_en == br48_en);

    // R6: a system pulse is preceded by a postscaler pulse
    assert_sys_after_post_R6: assert property (@(posedge clk) disable iff (rst)
        sys_en |-> $past(post_pulse));

    // R8: an instruction pulse is preceded by a system pulse
    assert_instr_after_sys_R8: assert property (@(posedge clk) disable iff (rst)
        instr_en |-> $past(sys_en));

    // R1: outputs are low one cycle after a reset edge
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> !(br96_en || br48_en || usb_en || pre_en || sys_en || instr_en));

endmodule

// File: tb/sim_pll_div_tree.sv
module sim_pll_div_tree;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] pre_sel = 3'd0;
    logic [1:0] post_sel = 2'd0;
    logic br96_en, br48_en, usb_en, pre_en, sys_en, instr_en;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #5 clk = ~clk;   // 100 MHz

    pll_div_tree u0 (
        .clk(clk), .rst(rst), .pre_sel(pre_sel), .post_sel(post_sel),
        .br96_en(br96_en), .br48_en(br48_en), .usb_en(usb_en),
        .pre_en(pre_en), .sys_en(sys_en), .instr_en(instr_en));

    // ---------------- reference model ----------------
    int pre_rem, post_rem, c48, c3, c2;
    bit p_prev, s_prev;
    bit e96, e48, epre, esys, einstr;

    function automatic int pre_div(input logic [2:0] s);
        int t[8] = '{1, 2, 3, 4, 5, 6, 8, 12};
        return t[s];
    endfunction

    always @(posedge clk) begin
        bit pnow;
        if (rst) begin
            pre_rem = pre_div(pre_sel);
            post_rem = 1 << post_sel;
            c48 = 0; c3 = 0; c2 = 0; p_prev = 0; s_prev = 0;
            e96 = 0; e48 = 0; epre = 0; esys = 0; einstr = 0;
        end else begin
            e96 = 1;
            e48 = (c48 == 1);
            c48 = 1 - c48;
            pre_rem = pre_rem - 1;
            epre = (pre_rem == 0);
            if (epre) pre_rem = pre_div(pre_sel);
            post_rem = post_rem - 1;
            pnow = (post_rem == 0);
            if (pnow) post_rem = 1 << post_sel;
            esys = p_prev && (c3 == 2);
            if (p_prev) c3 = (c3 + 1) % 3;
            p_prev = pnow;
            einstr = s_prev && (c2 == 1);
            if (s_prev) c2 = 1 - c2;
            s_prev = esys;
        end
    end

    task automatic check(input string tag, input logic act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", tag, cycles, act, exp);
        end
    endtask

    task automatic compare_all(input bit in_reset);
        if (in_reset) begin
            check("R1 br96_en reset", br96_en, 1'b0);
            check("R1 sys_en reset",  sys_en,  1'b0);
            check("R1 pre_en reset",  pre_en,  1'b0);
        end else begin
            check("R4 br96_en",          br96_en,  e96);
            check("R5 br48_en",          br48_en,  e48);
            check("R5 usb_en",           usb_en,   e48);
            check("R2/R3 pre_en",        pre_en,   epre);
            check("R6/R7/R9 sys_en",     sys_en,   esys);
            check("R8 instr_en",         instr_en, einstr);
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cycles++;
            compare_all(rst);
        end
    endtask

    // ---------------- stimulus ----------------
    initial begin
        run(3);
        rst = 1'b0;
        run(40);
        // R2 / R3: every prescaler code, changed mid-period
        for (int c = 1; c < 8; c++) begin
            pre_sel = 3'(c);
            run(37);
        end
        // R6 / R7: every postscaler code, changed mid-period
        for (int c = 1; c < 4; c++) begin
            post_sel = 2'(c);
            run(61);
        end
        post_sel = 2'd1;
        run(13);
        pre_sel = 3'd4;
        post_sel = 2'd0;   // R6: prescaler choice has no effect on sys_en
        run(50);
        // R1: reset in mid-run with new codes
        rst = 1'b1;
        pre_sel = 3'd2;
        post_sel = 2'd2;
        run(2);
        rst = 1'b0;
        run(120);
        post_sel = 2'd3;
        run(5);
        post_sel = 2'd0;   // R7: changed again before the boundary
        run(80);
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule